// File: doc/BRIEF.md
# SPI Controller with Mode-Fault Detection

This block is a byte-wide SPI engine that runs either as the clock-driving master or as a slave clocked from outside. Software reaches it through three 8-bit registers on a simple read/write strobe interface. These are a control register (enable and master select), a status/control register (flags, interrupt enables and bit order) and a data register. Writing the data register fills a one-byte transmit buffer. The buffer hands its byte to the shifter as soon as the shifter is free, so the next byte can be queued while the current one is still on the wire.

The block watches its slave-select input for a mode fault. A master that sees slave select driven low has a competing master on the bus, so it shuts itself off. A slave that sees slave select rise in the middle of a byte drops the partial byte and ignores the clock until slave select is low again. One interrupt line combines a mode-fault source with either a transfer-complete source or a buffer-empty source, chosen by software.

Top module: `spi_fault_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00 and the status register (address 1) reads 0x01: bit 7 transfer-complete 0, bits 6..1 all 0, bit 0 transmit-empty 1. The interrupt and the SCK output are low.
- R2: In master mode (control bit 1 = 1, bit 0 = 1), a queued byte is sent as eight SCK pulses with SCK idle low. MOSI changes after a falling edge and MISO is sampled on each rising edge. After the eighth bit, status bit 7 sets and the received byte reads back from the data register (address 2).
- R3: With status bit 3 clear, bytes shift most significant bit first. With it set, they shift least significant bit first, in both directions.
- R4: Status bit 0 clears when the data register is written. It sets again when the byte moves into an idle shifter. A byte written during a transfer moves at the end of that byte and goes out as the next byte.
- R5: While master mode is enabled, a low level on ss_ni sets the mode-fault flag (status bit 1) and clears the enable (control bit 0), which stops SCK.
- R6: A read of the status register clears the mode-fault flag. The read itself still returns the flag as set.
- R7: In slave mode (control bit 1 = 0, bit 0 = 1) with ss_ni low, the block samples mosi_i on rising sck_i, presents its queued byte on miso_o, and sets status bit 7 after eight bits.
- R8: In slave mode, ss_ni rising before the eighth bit sets the mode-fault flag and discards the partial byte. SCK edges are ignored while ss_ni is high. The next full byte sent with ss_ni low is received intact.
- R9: When status bit 2 is clear, irq_o follows the transfer-complete flag. When it is set, irq_o follows the transmit-empty flag and the transfer-complete flag has no effect.
- R10: The mode-fault flag drives irq_o only while status bit 4 is set.
- R11: A read of the data register clears the transfer-complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (triggers clear-on-read) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out, master mode |
| mosi_o | output | 1 | Serial data out, master mode |
| miso_i | input | 1 | Serial data in, master mode |
| sck_i | input | 1 | Serial clock in, slave mode |
| mosi_i | input | 1 | Serial data in, slave mode |
| miso_o | output | 1 | Serial data out, slave mode |
| ss_ni | input | 1 | Slave select, active low |

## Verification
The hardest case to reach is the slave-side abort. Slave select has to rise after a few bits have been clocked in, but before the byte completes, and then stray SCK pulses have to arrive while slave select is high. The bench drives a software SPI master that stops after three bits, raises slave select, and toggles SCK twice. It then checks that the fault flag is set and no completion was reported, and that a fresh full byte lands intact. Back-to-back master traffic is also awkward, because the second data write must land while the first byte is on the wire. The bench therefore forks the serial-side model against the register accesses.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int C_EN      = 0;
  localparam int C_MSTR    = 1;
  localparam int S_TXE     = 0;
  localparam int S_MODF    = 1;
  localparam int S_TXE_IE  = 2;
  localparam int S_LSB     = 3;
  localparam int S_MODF_IE = 4;
  localparam int S_DONE    = 7;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt_q;
  logic          sck_q, tick;

  assign tick = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         lsb_first_i,
  input  logic         sample_i,
  input  logic         shift_i,
  input  logic         in_bit_i,
  output logic         out_bit_o,
  output logic         idle_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int CW = $clog2(W);
  logic [W-1:0]  sh_q, nxt, rx_q;
  logic [CW-1:0] cnt_q;
  logic          half_q, in_q, last;

  assign nxt  = lsb_first_i ? {in_q, sh_q[W-1:1]} : {sh_q[W-2:0], in_q};
  assign last = (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      in_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= load_data_i;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (sample_i) begin
      in_q   <= in_bit_i;
      half_q <= 1'b1;
    end else if (shift_i && half_q) begin
      sh_q   <= nxt;
      half_q <= 1'b0;
      cnt_q  <= last ? '0 : cnt_q + 1'b1;
      if (last) rx_q <= nxt;
    end
  end

  assign out_bit_o = lsb_first_i ? sh_q[0] : sh_q[W-1];
  assign idle_o    = (cnt_q == '0) && !half_q;
  assign done_o    = shift_i && half_q && last && !clr_i && !load_i && !sample_i;
  assign rx_o      = rx_q;
endmodule

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl
  import spi_fault_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  input  logic        sck_i,
  input  logic        mosi_i,
  output logic        miso_o,
  input  logic        ss_ni
);
  logic en_q, mstr_q, done_q, modf_q, modf_ie_q, lsb_q, txe_ie_q, act_q;
  logic buf_full_q;
  logic [BYTE_W-1:0] buf_q, rx;
  logic [2:0] sync_q;
  logic [1:0] prev_q;
  logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data, txe;
  logic ss_s, sck_s, mosi_s, ss_rise, sck_rise, sck_fall;
  logic fault_m, fault_s, fault, core_clr, core_idle, core_done, move;
  logic g_rise, g_fall, run, sample, shift, out_bit;

  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign wr_data = wr_i && (addr_i == A_DATA);
  assign rd_stat = rd_i && (addr_i == A_STAT);
  assign rd_data = rd_i && (addr_i == A_DATA);
  assign txe     = !buf_full_q;

  spi_sync #(.W(3), .RST(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, mosi_i}),
    .q_o   (sync_q)
  );
  assign {sck_s, ss_s, mosi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b01;
    else         prev_q <= {sck_s, ss_s};
  end
  assign sck_rise = sck_s && !prev_q[1];
  assign sck_fall = !sck_s && prev_q[1];
  assign ss_rise  = ss_s && !prev_q[0];

  // master: competing driver on select; slave: select dropped mid-byte
  assign fault_m  = en_q && mstr_q && !ss_s;
  assign fault_s  = en_q && !mstr_q && ss_rise && !core_idle;
  assign fault    = fault_m || fault_s;
  assign core_clr = !en_q || fault || wr_ctrl;
  assign move     = en_q && buf_full_q && core_idle && !act_q && !core_clr;

  assign run = act_q && en_q && mstr_q;

  spi_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .sck_o (sck_o),
    .rise_o(g_rise),
    .fall_o(g_fall)
  );

  assign sample = mstr_q ? g_rise : (sck_rise && !ss_s);
  assign shift  = mstr_q ? g_fall : (sck_fall && !ss_s);

  spi_shift_core #(.W(BYTE_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (core_clr),
    .load_i     (move),
    .load_data_i(buf_q),
    .lsb_first_i(lsb_q),
    .sample_i   (sample),
    .shift_i    (shift),
    .in_bit_i   (mstr_q ? miso_i : mosi_s),
    .out_bit_o  (out_bit),
    .idle_o     (core_idle),
    .done_o     (core_done),
    .rx_o       (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      mstr_q     <= 1'b0;
      done_q     <= 1'b0;
      modf_q     <= 1'b0;
      modf_ie_q  <= 1'b0;
      lsb_q      <= 1'b0;
      txe_ie_q   <= 1'b0;
      act_q      <= 1'b0;
      buf_full_q <= 1'b0;
      buf_q      <= '0;
    end else begin
      if (wr_ctrl) mstr_q <= wdata_i[C_MSTR];
      if (fault_m)      en_q <= 1'b0;
      else if (wr_ctrl) en_q <= wdata_i[C_EN];

      if (wr_stat) begin
        modf_ie_q <= wdata_i[S_MODF_IE];
        lsb_q     <= wdata_i[S_LSB];
        txe_ie_q  <= wdata_i[S_TXE_IE];
      end

      if (fault)        modf_q <= 1'b1;
      else if (rd_stat) modf_q <= 1'b0;

      if (core_done)    done_q <= 1'b1;
      else if (rd_data) done_q <= 1'b0;

      if (wr_data) begin
        buf_q      <= wdata_i;
        buf_full_q <= 1'b1;
      end else if (move) begin
        buf_full_q <= 1'b0;
      end

      if (core_done || core_clr) act_q <= 1'b0;
      else if (move && mstr_q)   act_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[C_EN]   = en_q;
        rdata_o[C_MSTR] = mstr_q;
      end
      A_STAT: begin
        rdata_o[S_DONE]    = done_q;
        rdata_o[S_MODF_IE] = modf_ie_q;
        rdata_o[S_LSB]     = lsb_q;
        rdata_o[S_TXE_IE]  = txe_ie_q;
        rdata_o[S_MODF]    = modf_q;
        rdata_o[S_TXE]     = txe;
      end
      A_DATA:  rdata_o = rx;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o  = (txe_ie_q ? txe : done_q) || (modf_ie_q && modf_q);
  assign mosi_o = (mstr_q && act_q) ? out_bit : 1'b0;
  assign miso_o = out_bit;
endmodule

// File: rtl/spi_fault_ctrl_chk.sv
module spi_fault_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic mstr_i,
  input logic ss_s_i,
  input logic modf_i,
  input logic rd_stat_i,
  input logic sck_o_i,
  input logic txe_i,
  input logic core_idle_i
);
  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mstr_i && en_i) |=> !sck_o_i); // R2

  AST_MODF_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mstr_i && !ss_s_i) |=> (modf_i && !en_i)); // R5

  AST_MODF_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && mstr_i && ss_s_i) |=> !modf_i); // R6

  AST_TXE_MOVE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txe_i) |-> $past(core_idle_i)); // R4

  AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mstr_i && ss_s_i && $past(ss_s_i) && $past(en_i) && !$past(mstr_i))
      |-> core_idle_i); // R8
endmodule

bind spi_fault_ctrl spi_fault_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_q),
  .mstr_i     (mstr_q),
  .ss_s_i     (ss_s),
  .modf_i     (modf_q),
  .rd_stat_i  (rd_stat),
  .sck_o_i    (sck_o),
  .txe_i      (txe),
  .core_idle_i(core_idle)
);

// File: tb/spi_fault_ctrl_test.sv
module spi_fault_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, sck_o, mosi_o, miso_o;
  logic       miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_fault_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .ss_ni(ss_ni)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // slave model facing the master-mode pins
  task automatic mxfer(input logic [7:0] so, input logic lsb, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      int idx = lsb ? i : 7 - i;
      miso_i = so[idx];
      @(posedge sck_o);
      #1 got[idx] = mosi_o;
      @(negedge sck_o);
    end
  endtask

  // master model facing the slave-mode pins, msb first
  task automatic sxfer(input logic [7:0] si, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi_i = si[7-i];
      wait_clk(8);
      got[7-i] = miso_o;
      sck_i = 1'b1;
      wait_clk(8);
      sck_i = 1'b0;
    end
    wait_clk(8);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h01);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 sck", {7'd0, sck_o}, 8'h00);
  endtask

  task automatic t_master_msb;
    logic [7:0] v, m;
    wr(2'd0, 8'h03);
    wr(2'd2, 8'hC3);
    mxfer(8'h5A, 1'b0, m);
    chk("R2 mosi msb-first", m, 8'hC3);
    wait_clk(4);
    chk("R2 sck idle low", {7'd0, sck_o}, 8'h00);
    rd(2'd1, v); chk("R2 done flag", v, 8'h81);
    chk("R9 irq on done", {7'd0, irq_o}, 8'h01);
    rd(2'd2, v); chk("R2 rx byte", v, 8'h5A);
    rd(2'd1, v); chk("R11 done cleared", v, 8'h01);
    chk("R9 irq off, txe not selected", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_master_lsb;
    logic [7:0] v, m;
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h1E);
    mxfer(8'h4D, 1'b1, m);
    chk("R3 mosi lsb-first", m, 8'h1E);
    wait_clk(4);
    rd(2'd2, v); chk("R3 rx lsb-first", v, 8'h4D);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_back_to_back;
    logic [7:0] v, m1, m2, s1, s2;
    wr(2'd2, 8'hA5);
    fork
      begin
        mxfer(8'h11, 1'b0, m1);
        mxfer(8'h22, 1'b0, m2);
      end
      begin
        wait_clk(2);
        rd(2'd1, v); s1 = v;
        wr(2'd2, 8'h3C);
        rd(2'd1, v); s2 = v;
      end
    join
    chk("R4 txe set after move", s1 & 8'h01, 8'h01);
    chk("R4 txe clear while queued", s2 & 8'h01, 8'h00);
    chk("R4 first byte", m1, 8'hA5);
    chk("R4 queued byte follows", m2, 8'h3C);
    wait_clk(4);
    rd(2'd1, v); chk("R4 txe and done at end", v, 8'h81);
  endtask

  task automatic t_irq_select;
    logic [7:0] v, m;
    chk("R9 irq from done", {7'd0, irq_o}, 8'h01);
    wr(2'd1, 8'h04);
    chk("R9 irq from txe", {7'd0, irq_o}, 8'h01);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h77);
    wait_clk(2);
    chk("R9 done masked when txe selected", {7'd0, irq_o}, 8'h00);
    rd(2'd1, v); chk("R9 status", v, 8'h84);
    rd(2'd2, v); chk("R11 rx of second byte", v, 8'h22);
    rd(2'd1, v); chk("R11 done cleared by data read", v & 8'h80, 8'h00);
    wr(2'd0, 8'h03);
    mxfer(8'h00, 1'b0, m);
    chk("R4 held byte sent after enable", m, 8'h77);
    wait_clk(4);
    rd(2'd2, v);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_master_fault;
    logic [7:0] v;
    chk("R10 irq quiet before fault", {7'd0, irq_o}, 8'h00);
    ss_ni = 1'b0;
    wait_clk(5);
    chk("R10 modf masked", {7'd0, irq_o}, 8'h00);
    rd(2'd0, v); chk("R5 enable cleared", v, 8'h02);
    chk("R5 sck stopped", {7'd0, sck_o}, 8'h00);
    wr(2'd1, 8'h10);
    chk("R10 modf irq enabled", {7'd0, irq_o}, 8'h01);
    rd(2'd1, v); chk("R5 modf flag", v & 8'h02, 8'h02);
    rd(2'd1, v); chk("R6 modf cleared on read", v & 8'h02, 8'h00);
    chk("R10 irq drops with flag", {7'd0, irq_o}, 8'h00);
    wr(2'd1, 8'h00);
    ss_ni = 1'b1;
    wait_clk(4);
  endtask

  task automatic t_slave;
    logic [7:0] v, m;
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h96);
    wait_clk(2);
    ss_ni = 1'b0;
    wait_clk(4);
    sxfer(8'h69, 8, m);
    ss_ni = 1'b1;
    wait_clk(4);
    chk("R7 miso byte", m, 8'h96);
    rd(2'd1, v); chk("R7 done flag", v & 8'h80, 8'h80);
    rd(2'd2, v); chk("R7 rx byte", v, 8'h69);
  endtask

  task automatic t_slave_fault;
    logic [7:0] v, m;
    ss_ni = 1'b0;
    wait_clk(4);
    sxfer(8'hFF, 3, m);
    ss_ni = 1'b1;
    wait_clk(6);
    rd(2'd1, v); chk("R8 modf set, no done", v & 8'h82, 8'h02);
    mosi_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      wait_clk(8); sck_i = 1'b1;
      wait_clk(8); sck_i = 1'b0;
    end
    wait_clk(8);
    rd(2'd1, v); chk("R8 clocks ignored with select high", v & 8'h82, 8'h00);
    ss_ni = 1'b0;
    wait_clk(4);
    sxfer(8'h3C, 8, m);
    ss_ni = 1'b1;
    wait_clk(4);
    rd(2'd2, v); chk("R8 next byte intact", v, 8'h3C);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    t_reset();
    t_master_msb();
    t_master_lsb();
    t_back_to_back();
    t_irq_select();
    t_master_fault();
    t_slave();
    t_slave_fault();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule